// File: doc/BRIEF.md
# Scan-Chain Reuse Pattern Decompressor

This block turns a one-bit-per-pattern encoded test stream into complete scan patterns for a core under test (CUT). It does this by reusing the scan chains of another core as an on-chip tester. The tester's chains are joined into one serial ring. A 2:1 multiplexer at the ring input chooses between the external stream bit and a feedback wire that returns from the ring's end. The last cell of each connected tester chain drives the parallel scan input of one CUT chain.

A small sequencer alternates between two modes:
- A shift burst of as many cycles as the longest CUT chain. In these cycles scan-enable is high, the ring recirculates and the CUT shifts.
- A single capture cycle. Scan-enable is low, the CUT captures, and the ring takes exactly one new external bit.

Optional extra flip-flops in the feedback wire lengthen the ring. This is used to make the ring length coprime with the shift count. A plain CUT scan-register model is included, so the expanded pattern can be observed at the ports. In this model the CUT holds its contents during capture.

Top module: `scan_reuse_decomp`

## Requirements
- R1: While `rst_n` is low, every ring cell, every CUT cell, `scan_en`, `bit_req` and `pattern_done` are 0. The all-zero ring is the starting content for the first pattern.
- R2: While the sequencer is idle, the ring and the CUT register hold their values and `ext_bit` is ignored. `cut_si`, `tester_so` and `cut_state` do not change.
- R3: When `start` is high in an idle cycle, `scan_en` is high for exactly `CCH_LEN` consecutive cycles starting at the next edge. One capture cycle with `scan_en` low then follows.
- R4: `bit_req` is high only in the capture cycle. At the end of that cycle `ext_bit` enters the first cell of tester chain 0. In every shift cycle the ring input is instead the feedback output.
- R5: In each shift cycle, CUT chain k loads `cut_si[k]` into its cell 0 and moves its contents toward higher cell indices. `cut_si[k]` is the last cell of tester chain k. Bit k*`CCH_LEN`+j of `cut_state` is cell j of CUT chain k.
- R6: Tester chains numbered `NUM_CCH` and above feed no CUT chain but stay in the ring. `tester_so` is the last cell of the last tester chain, which is (`NUM_TCH`-1)*`TCH_LEN` ring positions after the tap of chain 0.
- R7: `FB_FLOPS` flip-flops sit between `tester_so` and the input multiplexer. A bit therefore returns to the same tap after `NUM_TCH`*`TCH_LEN`+`FB_FLOPS` active cycles.
- R8: `pattern_done` is a one-cycle pulse in the cycle that follows each capture cycle.
- R9: If `start` is high during a capture cycle, the next shift burst begins at the following edge. Otherwise the sequencer goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run a pattern, sampled when idle or in capture |
| ext_bit | input | 1 | Encoded stream bit, taken in the capture cycle |
| bit_req | output | 1 | High in the cycle whose closing edge consumes `ext_bit` |
| scan_en | output | 1 | CUT scan-enable; high selects circular mode in the ring |
| pattern_done | output | 1 | Pulse after each capture cycle |
| tester_so | output | 1 | Serial output of the tester's last chain |
| cut_si | output | NUM_CCH | Parallel scan inputs driven into the CUT chains |
| cut_state | output | NUM_CCH*CCH_LEN | Contents of the CUT scan-register model |

## Verification
The capture cycle is the point where injection and re-launch coincide. In that cycle the ring takes a stream bit instead of its feedback, and the sequencer decides from `start` whether the next burst begins immediately. The bench provokes this by holding `start` high across captures and by raising `start` only inside capture cycles. A behavioural ring and CUT model judges every cycle, so any bit lost or duplicated at the seam of back-to-back patterns is seen. A single-one stream then times the tap-to-serial-output and full-ring return distances.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_CAPT  = 2'd2
  } sq_state_t;

endpackage

// File: rtl/sdec_chain.sv
module sdec_chain #(
  parameter int LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic si,
  output logic so
);

  logic [LEN-1:0] cells_q;
  logic [LEN-1:0] cells_d;

  always_comb begin
    cells_d[0] = si;
    for (int j = 1; j < LEN; j++) begin
      cells_d[j] = cells_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
    end else if (en) begin
      cells_q <= cells_d;
    end
  end

  assign so = cells_q[LEN-1];

endmodule

// File: rtl/sdec_seq.sv
module sdec_seq
  import sdec_pkg::*;
#(
  parameter int SHIFTS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic scan_en,
  output logic bit_req,
  output logic ring_en,
  output logic done
);

  localparam int CW = (SHIFTS > 1) ? $clog2(SHIFTS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SHIFTS - 1);

  sq_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SHIFT;
          cnt_d   = '0;
        end
      end
      SQ_SHIFT: begin
        if (cnt_q == LAST) begin
          state_d = SQ_CAPT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_CAPT: begin
        done_d = 1'b1;
        cnt_d  = '0;
        state_d = start ? SQ_SHIFT : SQ_IDLE;
      end
      default: begin
        state_d = SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign scan_en = (state_q == SQ_SHIFT);
  assign bit_req = (state_q == SQ_CAPT);
  assign ring_en = (state_q != SQ_IDLE);
  assign done    = done_q;

  // R3: the burst ends after the last count in a single capture cycle
  p_burst_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SHIFT && cnt_q == LAST) |=> (state_q == SQ_CAPT));

  p_single_capt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CAPT) |=> (state_q != SQ_CAPT));

  // R9: start held in capture relaunches a burst from count zero
  p_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CAPT && start) |=> (state_q == SQ_SHIFT && cnt_q == '0));

endmodule

// File: rtl/sdec_ring.sv
module sdec_ring #(
  parameter int NT = 4,
  parameter int TL = 100,
  parameter int NC = 3,
  parameter int FB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          circ,
  input  logic          ext_bit,
  output logic [NC-1:0] taps,
  output logic          so
);

  logic [NT:0] link;
  logic        fb_out;

  assign link[0] = circ ? fb_out : ext_bit;

  for (genvar c = 0; c < NT; c++) begin : g_chain
    sdec_chain #(.LEN(TL)) chain_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .si    (link[c]),
      .so    (link[c+1])
    );
    if (c < NC) begin : g_tap
      assign taps[c] = link[c+1];
    end
  end

  assign so = link[NT];

  if (FB > 0) begin : g_fb
    sdec_chain #(.LEN(FB)) fb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .si    (link[NT]),
      .so    (fb_out)
    );
  end else begin : g_nofb
    assign fb_out = link[NT];
  end

  // R2: an idle ring shows frozen tap and serial outputs
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(so) && $stable(taps)));

endmodule

// File: rtl/sdec_cut.sv
module sdec_cut #(
  parameter int NC = 3,
  parameter int CL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NC-1:0]    si,
  output logic [NC*CL-1:0] state
);

  logic [NC*CL-1:0] state_q, state_d;

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      state_d[k*CL] = si[k];
      for (int j = 1; j < CL; j++) begin
        state_d[k*CL+j] = state_q[k*CL+j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/scan_reuse_decomp.sv
module scan_reuse_decomp #(
  parameter int NUM_TCH  = 4,
  parameter int TCH_LEN  = 100,
  parameter int NUM_CCH  = 3,
  parameter int CCH_LEN  = 8,
  parameter int FB_FLOPS = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       ext_bit,
  output logic                       bit_req,
  output logic                       scan_en,
  output logic                       pattern_done,
  output logic                       tester_so,
  output logic [NUM_CCH-1:0]         cut_si,
  output logic [NUM_CCH*CCH_LEN-1:0] cut_state
);

  localparam int RING_LEN = NUM_TCH * TCH_LEN + FB_FLOPS;

  logic ring_en;

  sdec_seq #(.SHIFTS(CCH_LEN)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .scan_en (scan_en),
    .bit_req (bit_req),
    .ring_en (ring_en),
    .done    (pattern_done)
  );

  sdec_ring #(
    .NT (NUM_TCH),
    .TL (TCH_LEN),
    .NC (NUM_CCH),
    .FB (FB_FLOPS)
  ) ring_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ring_en),
    .circ    (scan_en),
    .ext_bit (ext_bit),
    .taps    (cut_si),
    .so      (tester_so)
  );

  sdec_cut #(.NC(NUM_CCH), .CL(CCH_LEN)) cut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (scan_en),
    .si    (cut_si),
    .state (cut_state)
  );

  // R4: capture and circular mode never overlap
  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && bit_req));

  // R8: done follows every capture and lasts one cycle
  p_done_after_capt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> pattern_done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |=> !pattern_done);

  // R2: the CUT model holds outside shift cycles
  p_cut_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(cut_state));

  // R5: each CUT chain loads its own tester tap
  for (genvar k = 0; k < NUM_CCH; k++) begin : g_chk
    p_cut_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> (cut_state[k*CCH_LEN] == $past(cut_si[k])));
  end

  initial begin
    assert (RING_LEN > CCH_LEN);
  end

endmodule

// File: tb/scan_reuse_decomp_tb_top.sv
module scan_reuse_decomp_tb_top;

  localparam int NT = 4, TL = 100, NC = 3, CL = 8, FB = 1;
  localparam int RL = NT * TL + FB;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, ext_bit;
  logic bit_req, scan_en, pattern_done, tester_so;
  logic [NC-1:0]    cut_si;
  logic [NC*CL-1:0] cut_state;

  scan_reuse_decomp #(
    .NUM_TCH(NT), .TCH_LEN(TL), .NUM_CCH(NC), .CCH_LEN(CL), .FB_FLOPS(FB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_bit(ext_bit),
    .bit_req(bit_req), .scan_en(scan_en), .pattern_done(pattern_done),
    .tester_so(tester_so), .cut_si(cut_si), .cut_state(cut_state)
  );

  // behavioural reference: ring as a bit array, CUT as a 2-D array
  bit m_ring [RL];
  bit m_cut  [NC][CL];
  int m_st;   // 0 idle, 1 shifting, 2 capturing
  int m_cnt;
  bit m_done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", what, got, exp);
    end
  endtask

  function automatic logic [NC*CL-1:0] exp_cut();
    logic [NC*CL-1:0] v;
    for (int k = 0; k < NC; k++)
      for (int j = 0; j < CL; j++) v[k*CL+j] = m_cut[k][j];
    return v;
  endfunction

  function automatic logic [NC-1:0] exp_si();
    logic [NC-1:0] v;
    for (int k = 0; k < NC; k++) v[k] = m_ring[k*TL+TL-1];
    return v;
  endfunction

  task automatic compare_all();
    chk(scan_en == (m_st == 1), "R3 scan_en", 64'(scan_en), 64'(m_st == 1));
    chk(bit_req == (m_st == 2), "R4 bit_req", 64'(bit_req), 64'(m_st == 2));
    chk(pattern_done == m_done, "R8 pattern_done", 64'(pattern_done), 64'(m_done));
    chk(tester_so == m_ring[NT*TL-1], "R6 tester_so", 64'(tester_so), 64'(m_ring[NT*TL-1]));
    chk(cut_si == exp_si(), "R4/R7 cut_si", 64'(cut_si), 64'(exp_si()));
    chk(cut_state == exp_cut(), "R5 cut_state", 64'(cut_state), 64'(exp_cut()));
  endtask

  task automatic model_step(input bit s, input bit b);
    bit inb;
    if (m_st != 0) begin
      inb = (m_st == 1) ? m_ring[RL-1] : b;
      if (m_st == 1) begin
        for (int k = 0; k < NC; k++) begin
          for (int j = CL-1; j > 0; j--) m_cut[k][j] = m_cut[k][j-1];
          m_cut[k][0] = m_ring[k*TL+TL-1];
        end
      end
      for (int i = RL-1; i > 0; i--) m_ring[i] = m_ring[i-1];
      m_ring[0] = inb;
    end
    m_done = (m_st == 2);
    case (m_st)
      0: if (s) begin m_st = 1; m_cnt = 0; end
      1: if (m_cnt == CL-1) m_st = 2; else m_cnt++;
      default: begin m_st = s ? 1 : 0; m_cnt = 0; end
    endcase
  endtask

  task automatic cyc(input bit s, input bit b);
    @(negedge clk);
    compare_all();
    start   = s;
    ext_bit = b;
    model_step(s, b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; ext_bit = 1'b0;
    foreach (m_ring[i]) m_ring[i] = 1'b0;
    for (int k = 0; k < NC; k++) for (int j = 0; j < CL; j++) m_cut[k][j] = 1'b0;
    m_st = 0; m_cnt = 0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scan_en == 0 && bit_req == 0 && pattern_done == 0, "R1 control outputs in reset",
        64'({scan_en, bit_req, pattern_done}), 64'(0));
    chk(cut_state == '0 && cut_si == '0 && tester_so == 0, "R1 data outputs in reset",
        64'(cut_state), 64'(0));
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got %0d exp %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [NC*CL-1:0] held_cut;
    logic held_so;
    int en_cnt, done_cnt, t1, t2, t3, tick;
    bit req_seen, inj, prev0;

    do_reset();

    // R2: idle with a toggling stream leaves everything untouched
    held_cut = cut_state; held_so = tester_so; req_seen = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, bit'(i & 1));
      if (bit_req) req_seen = 1;
    end
    chk(cut_state == held_cut && tester_so == held_so && !req_seen, "R2 idle ignores ext_bit",
        64'(cut_state), 64'(held_cut));

    // R3, R8, R9: one lone pattern, then back to idle
    cyc(1'b1, 1'b1);
    en_cnt = 0; done_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b1);
      if (scan_en) en_cnt++;
      if (pattern_done) done_cnt++;
    end
    chk(en_cnt == CL, "R3 burst length", 64'(en_cnt), 64'(CL));
    chk(done_cnt == 1, "R8 one done pulse per pattern", 64'(done_cnt), 64'(1));
    chk(scan_en == 0 && bit_req == 0, "R9 idle after capture without start",
        64'({scan_en, bit_req}), 64'(0));

    // mixed start / stream traffic
    for (int i = 0; i < 1200; i++) cyc(($urandom % 10) < 7, bit'($urandom));

    // R9: start raised only inside capture cycles (relaunch seam)
    for (int i = 0; i < 400; i++)
      cyc((m_st == 2) || (m_st == 0 && ($urandom % 4 == 0)), bit'($urandom));

    // R6, R7: single one in the stream, timed around the ring
    do_reset();
    inj = 0; t1 = -1; t2 = -1; t3 = -1; tick = 0; prev0 = 0;
    for (int i = 0; i < 700; i++) begin
      bit b;
      b = (!inj && m_st == 2);
      if (b) inj = 1;
      cyc(1'b1, b);
      tick++;
      if (cut_si[0] && !prev0) begin
        if (t1 < 0) t1 = tick; else if (t3 < 0) t3 = tick;
      end
      if (tester_so && t2 < 0) t2 = tick;
      prev0 = cut_si[0];
    end
    chk(t1 >= 0 && (t2 - t1) == (NT-1)*TL, "R6 tap0 to serial out distance",
        64'(t2 - t1), 64'((NT-1)*TL));
    chk(t1 >= 0 && (t3 - t1) == RL, "R7 full ring return distance",
        64'(t3 - t1), 64'(RL));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule